// File: doc/BRIEF.md
# Producer-ID Register File with Broadcast Snooping

This block is the register file of one processor in a machine where a single sequential program is split among several processors. Each of its fifteen entries keeps a data value together with the ID of the instruction that produced it. An ID is the instruction's line number with an iteration field placed above it. Operands are never read by register number: a functional unit presents the producer IDs it needs, and every entry compares them with its own stored ID at the same time. A hit returns the value. A miss tells the unit that the operand will arrive from elsewhere.

Every processor also sees a broadcast of each program instruction, whether it runs locally or not. The register file inspects one broadcast instruction per clock. If the broadcast names a destination register that holds an older result, that entry is dropped. If either broadcast source operand ID matches a valid local entry, the matching value is placed on one of two send outputs for the network to forward.

Top module: `id_regfile`

## Requirements
- R1: After reset every entry is empty. Lookups then miss, and both send outputs are idle: hit flag 0 and data 0.
- R2: When `wr_en` is 1 and `wr_reg` is in the range 1..15, the rising edge loads `wr_id` and `wr_data` into that entry and marks it valid. When `wr_reg` is 0, nothing is written.
- R3: `rd_hit_a`/`rd_data_a` and `rd_hit_b`/`rd_data_b` follow `iss_id_a` and `iss_id_b` combinationally. A lookup hits when a valid entry stores exactly that ID. If several entries match, the lowest register number supplies the data.
- R4: On a lookup miss the hit flag is 0 and the data is 0. Entries that are not valid never match.
- R5: An ID is {iteration, line}: the top ITER_W bits hold the iteration and the low LINE_W bits hold the line. When `bc_valid` is 1 and `bc_dst` is in 1..15, the destination entry is cleared at the edge if it is valid and its stored ID is older than `bc_id`. Older means the iteration fields differ (a wrapped iteration counts as later), or the iterations are equal and the stored line is smaller.
- R6: A broadcast leaves the destination entry valid when it has the same iteration and a line greater than or equal to the broadcast line. A broadcast with `bc_dst` equal to 0 changes no entry.
- R7: If a write and an invalidation select the same entry in the same cycle, the write wins and the entry holds the written ID and data.
- R8: The send outputs are registered. One cycle after a cycle with `bc_valid` at 1, `snd_hit_a`/`snd_data_a` report the lowest-numbered valid entry whose ID equals `bc_op_a`, and the `b` outputs do the same for `bc_op_b`. On a miss, or after a cycle without a broadcast, the flag is 0 and the data is 0.
- R9: The send lookup uses the entry contents that held before the edge. A write or invalidation in the broadcast's own cycle does not alter what is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_id_a | input | ID_W | First operand producer ID from the issue bus |
| iss_id_b | input | ID_W | Second operand producer ID from the issue bus |
| rd_hit_a | output | 1 | First lookup found a matching entry |
| rd_data_a | output | DATA_W | Value for the first operand |
| rd_hit_b | output | 1 | Second lookup found a matching entry |
| rd_data_b | output | DATA_W | Value for the second operand |
| wr_en | input | 1 | Result write strobe |
| wr_reg | input | REG_W | Destination register number, 0 means none |
| wr_id | input | ID_W | ID of the producing instruction |
| wr_data | input | DATA_W | Result value |
| bc_valid | input | 1 | A broadcast instruction is present this cycle |
| bc_id | input | ID_W | ID of the broadcast instruction |
| bc_dst | input | REG_W | Destination register of the broadcast, 0 means none |
| bc_op_a | input | ID_W | First source operand ID of the broadcast |
| bc_op_b | input | ID_W | Second source operand ID of the broadcast |
| snd_hit_a | output | 1 | Local value found for the first broadcast operand |
| snd_data_a | output | DATA_W | Value to send for the first broadcast operand |
| snd_hit_b | output | 1 | Local value found for the second broadcast operand |
| snd_data_b | output | DATA_W | Value to send for the second broadcast operand |

## Verification
Two situations are hard to reach from the ports: a write and a stale-entry invalidation that land on one register in the same cycle, and a broadcast that asks for a value while that same value is being overwritten. Directed sequences first build a known entry, then drive both events in one cycle, and check the result through a lookup or the following send output. The iteration wrap is reached directly by storing an entry of iteration 1 and broadcasting a lower line of iteration 0. Random traffic then draws IDs from a small pool of lines, so that duplicate IDs, hits and invalidations occur often.

// File: rtl/idrf_pkg.sv
package idrf_pkg;

    localparam int DEF_LINE_W = 7;
    localparam int DEF_ITER_W = 1;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_NREGS  = 15;

    // Action taken by one storage entry in a cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DROP = 2'd2
    } entry_act_e;

endpackage

// File: rtl/idrf_entry.sv
module idrf_entry
    import idrf_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W,
    parameter int ITER_W = DEF_ITER_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int ID_W  = LINE_W + ITER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bc_sel,
    input  logic [ID_W-1:0]   bc_id,
    output logic              vld_o,
    output logic [ID_W-1:0]   id_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } ent_t;

    ent_t       st_d, st_q;
    entry_act_e act;
    logic       stale;

    logic [ITER_W-1:0] own_iter, bc_iter;
    logic [LINE_W-1:0] own_line, bc_line;

    always_comb begin
        own_iter = st_q.id[ID_W-1:LINE_W];
        own_line = st_q.id[LINE_W-1:0];
        bc_iter  = bc_id[ID_W-1:LINE_W];
        bc_line  = bc_id[LINE_W-1:0];
        // A different iteration is always later (wrap-aware); same iteration compares lines
        stale = (own_iter != bc_iter) || (own_line < bc_line);

        act = ACT_HOLD;
        if (wr_sel) begin
            act = ACT_LOAD;
        end else if (bc_sel && st_q.vld && stale) begin
            act = ACT_DROP;
        end

        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.vld  = 1'b1;
                st_d.id   = wr_id;
                st_d.data = wr_data;
            end
            ACT_DROP: st_d.vld = 1'b0;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign id_o   = st_q.id;
    assign data_o = st_q.data;

endmodule

// File: rtl/idrf_match.sv
module idrf_match #(
    parameter int N      = 15,
    parameter int ID_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic [N-1:0]             vld,
    input  logic [N-1:0][ID_W-1:0]   ids,
    input  logic [N-1:0][DATA_W-1:0] data,
    input  logic [ID_W-1:0]          key,
    output logic                     hit_o,
    output logic [DATA_W-1:0]        data_o
);

    logic [N-1:0] match;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            match[i] = vld[i] && (ids[i] == key);
        end
        hit_o  = |match;
        data_o = '0;
        // Scan downward so that the lowest matching index is assigned last
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                data_o = data[i];
            end
        end
    end

endmodule

// File: rtl/id_regfile.sv
module id_regfile
    import idrf_pkg::*;
#(
    parameter int LINE_W   = DEF_LINE_W,
    parameter int ITER_W   = DEF_ITER_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int NUM_REGS = DEF_NREGS,
    localparam int ID_W    = LINE_W + ITER_W,
    localparam int REG_W   = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   iss_id_a,
    input  logic [ID_W-1:0]   iss_id_b,
    output logic              rd_hit_a,
    output logic [DATA_W-1:0] rd_data_a,
    output logic              rd_hit_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bc_valid,
    input  logic [ID_W-1:0]   bc_id,
    input  logic [REG_W-1:0]  bc_dst,
    input  logic [ID_W-1:0]   bc_op_a,
    input  logic [ID_W-1:0]   bc_op_b,
    output logic              snd_hit_a,
    output logic [DATA_W-1:0] snd_data_a,
    output logic              snd_hit_b,
    output logic [DATA_W-1:0] snd_data_b
);

    localparam int NPORTS = 4;  // two issue lookups, two send lookups

    logic [NUM_REGS-1:0]             ent_vld;
    logic [NUM_REGS-1:0][ID_W-1:0]   ent_id;
    logic [NUM_REGS-1:0][DATA_W-1:0] ent_data;
    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0]             bc_sel;

    // Storage entries, register number i+1 lives in slot i
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        assign wr_sel[i] = wr_en    && (wr_reg == REG_W'(i + 1));
        assign bc_sel[i] = bc_valid && (bc_dst == REG_W'(i + 1));

        idrf_entry #(
            .LINE_W (LINE_W),
            .ITER_W (ITER_W),
            .DATA_W (DATA_W)
        ) ent_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel[i]),
            .wr_id   (wr_id),
            .wr_data (wr_data),
            .bc_sel  (bc_sel[i]),
            .bc_id   (bc_id),
            .vld_o   (ent_vld[i]),
            .id_o    (ent_id[i]),
            .data_o  (ent_data[i])
        );
    end

    // Associative lookups
    logic [NPORTS-1:0][ID_W-1:0]   lk_key;
    logic [NPORTS-1:0][NUM_REGS-1:0] lk_vld;
    logic [NPORTS-1:0]             lk_hit;
    logic [NPORTS-1:0][DATA_W-1:0] lk_data;

    always_comb begin
        lk_key[0] = iss_id_a;
        lk_key[1] = iss_id_b;
        lk_key[2] = bc_op_a;
        lk_key[3] = bc_op_b;
        lk_vld[0] = ent_vld;
        lk_vld[1] = ent_vld;
        lk_vld[2] = bc_valid ? ent_vld : '0;
        lk_vld[3] = bc_valid ? ent_vld : '0;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_lk
        idrf_match #(
            .N      (NUM_REGS),
            .ID_W   (ID_W),
            .DATA_W (DATA_W)
        ) match_i (
            .vld    (lk_vld[p]),
            .ids    (ent_id),
            .data   (ent_data),
            .key    (lk_key[p]),
            .hit_o  (lk_hit[p]),
            .data_o (lk_data[p])
        );
    end

    assign rd_hit_a  = lk_hit[0];
    assign rd_data_a = lk_data[0];
    assign rd_hit_b  = lk_hit[1];
    assign rd_data_b = lk_data[1];

    // Registered send stage
    typedef struct packed {
        logic              hit_a;
        logic [DATA_W-1:0] data_a;
        logic              hit_b;
        logic [DATA_W-1:0] data_b;
    } snd_t;

    snd_t snd_d, snd_q;

    always_comb begin
        snd_d.hit_a  = lk_hit[2];
        snd_d.data_a = lk_data[2];
        snd_d.hit_b  = lk_hit[3];
        snd_d.data_b = lk_data[3];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snd_q <= '0;
        end else begin
            snd_q <= snd_d;
        end
    end

    assign snd_hit_a  = snd_q.hit_a;
    assign snd_data_a = snd_q.data_a;
    assign snd_hit_b  = snd_q.hit_b;
    assign snd_data_b = snd_q.data_b;

endmodule

// File: rtl/id_regfile_chk.sv
module id_regfile_chk #(
    parameter int LINE_W   = 7,
    parameter int ITER_W   = 1,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 15,
    localparam int ID_W    = LINE_W + ITER_W,
    localparam int REG_W   = $clog2(NUM_REGS + 1)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [REG_W-1:0]                wr_reg,
    input logic [ID_W-1:0]                 wr_id,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            bc_valid,
    input logic [ID_W-1:0]                 bc_id,
    input logic [REG_W-1:0]                bc_dst,
    input logic                            rd_hit_a,
    input logic [DATA_W-1:0]               rd_data_a,
    input logic                            rd_hit_b,
    input logic [DATA_W-1:0]               rd_data_b,
    input logic                            snd_hit_a,
    input logic                            snd_hit_b,
    input logic [NUM_REGS-1:0]             ent_vld,
    input logic [NUM_REGS-1:0][ID_W-1:0]   ent_id,
    input logic [NUM_REGS-1:0][DATA_W-1:0] ent_data
);

    logic             dst_ok, wr_ok, tgt_old;
    logic [REG_W-1:0] dst_ix, wr_ix;
    logic [ID_W-1:0]  tgt_id;

    always_comb begin
        dst_ok  = (bc_dst != '0) && (int'(bc_dst) <= NUM_REGS);
        wr_ok   = (wr_reg != '0) && (int'(wr_reg) <= NUM_REGS);
        dst_ix  = dst_ok ? bc_dst - REG_W'(1) : '0;
        wr_ix   = wr_ok ? wr_reg - REG_W'(1) : '0;
        tgt_id  = ent_id[dst_ix];
        tgt_old = (tgt_id[ID_W-1:LINE_W] != bc_id[ID_W-1:LINE_W])
               || (tgt_id[LINE_W-1:0] < bc_id[LINE_W-1:0]);
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ent_vld == '0));

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok) |=> (ent_vld[$past(wr_ix)] && ent_id[$past(wr_ix)] == $past(wr_id)
                              && ent_data[$past(wr_ix)] == $past(wr_data)));

    // R3
    rd_hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_a || rd_hit_b) |-> (ent_vld != '0));

    // R4
    rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit_a |-> rd_data_a == '0) and (!rd_hit_b |-> rd_data_b == '0));

    // R5
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && dst_ok && ent_vld[dst_ix] && tgt_old && !(wr_en && wr_reg == bc_dst))
        |=> !ent_vld[$past(dst_ix)]);

    // R7
    wr_beats_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && bc_valid && wr_reg == bc_dst) |=> ent_vld[$past(wr_ix)]);

    // R8
    snd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_valid |=> (!snd_hit_a && !snd_hit_b));

endmodule

bind id_regfile id_regfile_chk #(
    .LINE_W   (LINE_W),
    .ITER_W   (ITER_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_reg    (wr_reg),
    .wr_id     (wr_id),
    .wr_data   (wr_data),
    .bc_valid  (bc_valid),
    .bc_id     (bc_id),
    .bc_dst    (bc_dst),
    .rd_hit_a  (rd_hit_a),
    .rd_data_a (rd_data_a),
    .rd_hit_b  (rd_hit_b),
    .rd_data_b (rd_data_b),
    .snd_hit_a (snd_hit_a),
    .snd_hit_b (snd_hit_b),
    .ent_vld   (ent_vld),
    .ent_id    (ent_id),
    .ent_data  (ent_data)
);

// File: tb/id_regfile_tb_top.sv
`timescale 1ns/100ps
module id_regfile_tb_top;

    localparam int LINE_W = 7;
    localparam int ITER_W = 1;
    localparam int DATA_W = 16;
    localparam int NREGS  = 15;
    localparam int ID_W   = LINE_W + ITER_W;
    localparam int REG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ID_W-1:0]   iss_id_a = '0, iss_id_b = '0;
    logic              rd_hit_a, rd_hit_b;
    logic [DATA_W-1:0] rd_data_a, rd_data_b;
    logic              wr_en = 1'b0;
    logic [REG_W-1:0]  wr_reg = '0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              bc_valid = 1'b0;
    logic [ID_W-1:0]   bc_id = '0, bc_op_a = '0, bc_op_b = '0;
    logic [REG_W-1:0]  bc_dst = '0;
    logic              snd_hit_a, snd_hit_b;
    logic [DATA_W-1:0] snd_data_a, snd_data_b;

    always #2.5 clk = ~clk;

    id_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .iss_id_a(iss_id_a), .iss_id_b(iss_id_b),
        .rd_hit_a(rd_hit_a), .rd_data_a(rd_data_a),
        .rd_hit_b(rd_hit_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_id(wr_id), .wr_data(wr_data),
        .bc_valid(bc_valid), .bc_id(bc_id), .bc_dst(bc_dst),
        .bc_op_a(bc_op_a), .bc_op_b(bc_op_b),
        .snd_hit_a(snd_hit_a), .snd_data_a(snd_data_a),
        .snd_hit_b(snd_hit_b), .snd_data_b(snd_data_b)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the entries
    logic              mvld [1:NREGS];
    logic [ID_W-1:0]   mid  [1:NREGS];
    logic [DATA_W-1:0] mdat [1:NREGS];

    function automatic logic [ID_W-1:0] mk(input int it, input int ln);
        return {ITER_W'(it), LINE_W'(ln)};
    endfunction

    // Broadcast id is newer than stored id: other iteration, or larger line
    function automatic bit newer(input logic [ID_W-1:0] st, input logic [ID_W-1:0] bc);
        if (st[ID_W-1] != bc[ID_W-1]) return 1'b1;
        return bc[LINE_W-1:0] > st[LINE_W-1:0];
    endfunction

    function automatic void lookup(input logic [ID_W-1:0] k, output logic h,
                                   output logic [DATA_W-1:0] d);
        h = 1'b0;
        d = '0;
        for (int r = 1; r <= NREGS; r++) begin
            if (!h && mvld[r] && mid[r] == k) begin
                h = 1'b1;
                d = mdat[r];
            end
        end
    endfunction

    task automatic chk(input string tag, input logic ah, input logic [DATA_W-1:0] ad,
                       input logic eh, input logic [DATA_W-1:0] ed);
        n_checks++;
        if (ah !== eh || ad !== ed) begin
            n_fail++;
            $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", tag, ah, ad, eh, ed);
        end
    endtask

    task automatic drive(input logic we, input int wr, input logic [ID_W-1:0] wi,
                         input logic [DATA_W-1:0] wd, input logic bv,
                         input logic [ID_W-1:0] bi, input int bd,
                         input logic [ID_W-1:0] oa, input logic [ID_W-1:0] ob);
        wr_en = we; wr_reg = REG_W'(wr); wr_id = wi; wr_data = wd;
        bc_valid = bv; bc_id = bi; bc_dst = REG_W'(bd); bc_op_a = oa; bc_op_b = ob;
    endtask

    task automatic idle();
        drive(1'b0, 0, '0, '0, 1'b0, '0, 0, '0, '0);
    endtask

    task automatic probe(input logic [ID_W-1:0] ka, input logic [ID_W-1:0] kb, input string tag);
        logic h;
        logic [DATA_W-1:0] d;
        iss_id_a = ka;
        iss_id_b = kb;
        #1;
        lookup(ka, h, d);
        chk({tag, " read a"}, rd_hit_a, rd_data_a, h, d);
        lookup(kb, h, d);
        chk({tag, " read b"}, rd_hit_b, rd_data_b, h, d);
    endtask

    // One clock: expected sends and next model from pre-edge state
    task automatic tick(input string stag);
        logic ha, hb;
        logic [DATA_W-1:0] da, db;
        logic              nv [1:NREGS];
        logic [ID_W-1:0]   ni [1:NREGS];
        logic [DATA_W-1:0] nd [1:NREGS];
        ha = 1'b0; hb = 1'b0; da = '0; db = '0;
        if (bc_valid) begin
            lookup(bc_op_a, ha, da);
            lookup(bc_op_b, hb, db);
        end
        for (int r = 1; r <= NREGS; r++) begin
            nv[r] = mvld[r]; ni[r] = mid[r]; nd[r] = mdat[r];
            if (wr_en && int'(wr_reg) == r) begin
                nv[r] = 1'b1; ni[r] = wr_id; nd[r] = wr_data;
            end else if (bc_valid && int'(bc_dst) == r && mvld[r] && newer(mid[r], bc_id)) begin
                nv[r] = 1'b0;
            end
        end
        @(posedge clk);
        for (int r = 1; r <= NREGS; r++) begin
            mvld[r] = nv[r]; mid[r] = ni[r]; mdat[r] = nd[r];
        end
        @(negedge clk);
        chk({stag, " send a"}, snd_hit_a, snd_data_a, ha, da);
        chk({stag, " send b"}, snd_hit_b, snd_data_b, hb, db);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: hit=0 data=0 expected hit=1 data=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        for (int r = 1; r <= NREGS; r++) begin
            mvld[r] = 1'b0; mid[r] = '0; mdat[r] = '0;
        end
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        probe(mk(0, 0), mk(1, 3), "R1");
        chk("R1 send a idle", snd_hit_a, snd_data_a, 1'b0, '0);
        chk("R1 send b idle", snd_hit_b, snd_data_b, 1'b0, '0);

        // R2: write then lookup; register 0 write ignored
        drive(1'b1, 3, mk(0, 5), 16'h1111, 1'b0, '0, 0, '0, '0);
        tick("R8");
        drive(1'b1, 0, mk(0, 6), 16'hdead, 1'b0, '0, 0, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 5), mk(0, 6), "R2");

        // R3: duplicate ID in registers 7 and 2, lowest wins
        drive(1'b1, 7, mk(0, 9), 16'h2222, 1'b0, '0, 0, '0, '0);
        tick("R8");
        drive(1'b1, 2, mk(0, 9), 16'h3333, 1'b0, '0, 0, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 9), mk(0, 5), "R3");

        // R4: misses, including other iteration of a stored line
        probe(mk(1, 5), mk(0, 100), "R4");

        // R5: older entry in register 3 dropped
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 12), 3, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 5), mk(0, 9), "R5");

        // R6: equal line, smaller line, and no destination keep the entry
        drive(1'b1, 4, mk(0, 20), 16'h4444, 1'b0, '0, 0, '0, '0);
        tick("R8");
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 20), 4, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 20), mk(0, 20), "R6");
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 15), 4, '0, '0);
        tick("R8");
        drive(1'b0, 0, '0, '0, 1'b1, mk(1, 0), 0, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 20), mk(0, 9), "R6");

        // R5: iteration wrap, stored {1,30}, broadcast {0,2} is later
        drive(1'b1, 5, mk(1, 30), 16'h5555, 1'b0, '0, 0, '0, '0);
        tick("R8");
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 2), 5, '0, '0);
        tick("R8");
        idle();
        probe(mk(1, 30), mk(0, 20), "R5");

        // R7: write and invalidation on register 6 in one cycle
        drive(1'b1, 6, mk(0, 1), 16'h6666, 1'b0, '0, 0, '0, '0);
        tick("R8");
        drive(1'b1, 6, mk(0, 40), 16'h7777, 1'b1, mk(0, 41), 6, '0, '0);
        tick("R8");
        idle();
        probe(mk(0, 40), mk(0, 1), "R7");

        // R8: send both operands
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 50), 0, mk(0, 9), mk(0, 40));
        tick("R8");
        drive(1'b0, 0, '0, '0, 1'b1, mk(0, 51), 0, mk(0, 77), mk(0, 20));
        tick("R8");

        // R9: overwrite and invalidation in the broadcast's cycle do not change sends
        drive(1'b1, 2, mk(0, 9), 16'h9999, 1'b1, mk(0, 60), 6, mk(0, 9), mk(0, 40));
        tick("R9");
        idle();
        probe(mk(0, 9), mk(0, 40), "R9");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [ID_W-1:0] ka, kb;
            drive(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                  mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15))),
                  DATA_W'($urandom),
                  1'($urandom_range(0, 1)),
                  mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15))),
                  int'($urandom_range(0, 15)),
                  mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15))),
                  mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15))));
            ka = mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
            kb = mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
            probe(ka, kb, "R3");
            tick("R8");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule